// File: doc/BRIEF.md
# Tiled 2x2 Box Smoother

This block produces a smoothed copy of an 8-bit grayscale frame. The source frame sits in a pixel memory the block reads through a simple address/data port; the smoothed frame goes out through a write port into a second memory. After a start pulse the engine walks the frame one square tile at a time. For each pixel it reads a 2x2 window from the source, averages the four samples and writes the result at the pixel's own position.

Inside a tile the window normally covers the pixel, its right neighbour, the pixel below and the pixel below-right. On a tile's last column the left neighbour stands in for the right one. On a tile's last row the row above stands in for the row below. As a result no read ever crosses a tile boundary to the right or downward. Frame width, frame height, tile edge and pixel width are parameters. The frame dimensions must be whole multiples of the tile edge, and the tile edge must be at least 2.

Top module: `tile_smoother`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge (synchronous, active low), the next cycle shows `busy`, `done`, `rd_en` and `wr_en` all at 0, and any frame in progress is abandoned.
- R2: A `start` sampled high while idle makes `busy` and `rd_en` high in the next cycle. From that cycle on, one read is issued in every cycle. For each pixel the four reads come in the order centre, horizontal neighbour, vertical neighbour, diagonal neighbour. Without `start` the block issues no reads.
- R3: The read and write address of frame pixel (x, y) is y*FRAME_W + x.
- R4: For a pixel at tile-local row i and column j, the horizontal neighbour is x+1, or x-1 when j = TILE-1. The vertical neighbour is y+1, or y-1 when i = TILE-1. At the tile's bottom-right pixel both substitutions apply.
- R5: Pixels inside a tile are visited row by row, with the column advancing fastest. Tiles are visited in raster order, with the tile column advancing fastest. The first tile's origin is (0,0), and the origin of tile (tx, ty) is (tx*TILE, ty*TILE).
- R6: Each result equals the four-sample sum shifted right by 2 (truncated). It is written to the centre pixel's address, with `wr_en` high exactly two cycles after the cycle in which that pixel's diagonal read was issued.
- R7: `done` is high for exactly one cycle, together with the write of the frame's last pixel. `busy` stays high from the cycle after the accepted start through the `done` cycle, and is low in the cycle after.
- R8: A `start` pulse while `busy` is high has no effect: the read sequence, the writes and the completion time continue unchanged.
- R9: Over one frame, every pixel of the result frame is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one frame pass when idle |
| busy | output | 1 | Frame pass in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Source read request |
| rd_addr | output | $clog2(FRAME_W*FRAME_H) | Source read address |
| rd_data | input | PIX_W | Source pixel, valid the cycle after the request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | $clog2(FRAME_W*FRAME_H) | Result write address |
| wr_data | output | PIX_W | Averaged pixel |

## Verification
The in-RTL properties check on every cycle that:
- read addresses stay inside the frame;
- each horizontal read lies one address from its centre, and each vertical read lies one frame row from it;
- every write trails a diagonal read by two cycles;
- `done` is a single-cycle pulse raised while `busy` is still high;
- `busy` does not drop before `done`.

Only the bench scenarios can show the rest:
- which neighbour is picked at tile edges;
- the exact tile and pixel visiting order;
- the averaged values for several source patterns;
- that a start during a pass is ignored;
- that a reset in mid-frame abandons the pass and a fresh start begins again at address 0.

// File: rtl/tile_smoother_pkg.sv
// Shared types and helpers for the tiled 2x2 box smoother.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package tile_smoother_pkg;

    // Order in which the four window samples of one pixel are fetched.
    typedef enum logic [1:0] {
        PH_CTR  = 2'd0,
        PH_HORZ = 2'd1,
        PH_VERT = 2'd2,
        PH_DIAG = 2'd3
    } phase_e;

    // Bit width needed to hold values 0..n-1, never below 1.
    function automatic int wid(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tile_walker.sv
// Tile walker: steps the tile column/row, the local row/column and the
// window phase for one frame pass, one read phase per cycle.
// Assumes FRAME_W and FRAME_H are multiples of TILE.
module tile_walker
    import tile_smoother_pkg::*;
#(
    parameter int FRAME_W = 320,
    parameter int FRAME_H = 240,
    parameter int TILE    = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   go,
    output logic                                   run,
    output logic [wid(FRAME_W / TILE)-1:0]         tx,
    output logic [wid(FRAME_H / TILE)-1:0]         ty,
    output logic [wid(TILE)-1:0]                   li,
    output logic [wid(TILE)-1:0]                   lj,
    output phase_e                                 ph,
    output logic                                   last
);
    localparam int TX_N = FRAME_W / TILE;
    localparam int TY_N = FRAME_H / TILE;
    localparam int TXW  = wid(TX_N);
    localparam int TYW  = wid(TY_N);
    localparam int LW   = wid(TILE);

    logic end_col, end_row, end_tx, end_ty;

    // Wrap conditions of each counter.
    always_comb begin
        end_col = (lj == LW'(TILE - 1));
        end_row = (li == LW'(TILE - 1));
        end_tx  = (tx == TXW'(TX_N - 1));
        end_ty  = (ty == TYW'(TY_N - 1));
        last    = run && (ph == PH_DIAG) && end_col && end_row && end_tx && end_ty;
    end

    // Nested counters: phase, column, row, tile column, tile row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            ph  <= PH_CTR;
            lj  <= '0;
            li  <= '0;
            tx  <= '0;
            ty  <= '0;
        end else if (go) begin
            run <= 1'b1;
            ph  <= PH_CTR;
            lj  <= '0;
            li  <= '0;
            tx  <= '0;
            ty  <= '0;
        end else if (run) begin
            ph <= phase_e'(ph + 2'd1);
            if (ph == PH_DIAG) begin
                if (!end_col) begin
                    lj <= lj + LW'(1);
                end else begin
                    lj <= '0;
                    if (!end_row) begin
                        li <= li + LW'(1);
                    end else begin
                        li <= '0;
                        if (!end_tx) begin
                            tx <= tx + TXW'(1);
                        end else begin
                            tx <= '0;
                            if (!end_ty) begin
                                ty <= ty + TYW'(1);
                            end else begin
                                ty  <= '0;
                                run <= 1'b0;
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/window_addr.sv
// Window address generator: turns tile/local position and phase into the
// linear source address, mirroring the neighbour at a tile's last column
// or row. Purely combinational; assumes TILE >= 2.
module window_addr
    import tile_smoother_pkg::*;
#(
    parameter int FRAME_W = 320,
    parameter int FRAME_H = 240,
    parameter int TILE    = 10
) (
    input  logic [wid(FRAME_W / TILE)-1:0]         tx,
    input  logic [wid(FRAME_H / TILE)-1:0]         ty,
    input  logic [wid(TILE)-1:0]                   li,
    input  logic [wid(TILE)-1:0]                   lj,
    input  phase_e                                 ph,
    output logic [wid(FRAME_W * FRAME_H)-1:0]      rd_addr,
    output logic [wid(FRAME_W * FRAME_H)-1:0]      ctr_addr
);
    localparam int XW = wid(FRAME_W);
    localparam int YW = wid(FRAME_H);
    localparam int AW = wid(FRAME_W * FRAME_H);
    localparam int LW = wid(TILE);

    logic [XW-1:0] cx, hx, sx;
    logic [YW-1:0] cy, vy, sy;

    // Centre coordinate, mirrored neighbours and the sample chosen by phase.
    always_comb begin
        cx = XW'(tx) * XW'(TILE) + XW'(lj);
        cy = YW'(ty) * YW'(TILE) + YW'(li);
        hx = (lj == LW'(TILE - 1)) ? cx - XW'(1) : cx + XW'(1);
        vy = (li == LW'(TILE - 1)) ? cy - YW'(1) : cy + YW'(1);
        sx = (ph == PH_CTR || ph == PH_VERT) ? cx : hx;
        sy = (ph == PH_CTR || ph == PH_HORZ) ? cy : vy;
        rd_addr  = AW'(sy) * AW'(FRAME_W) + AW'(sx);
        ctr_addr = AW'(cy) * AW'(FRAME_W) + AW'(cx);
    end

endmodule

// File: rtl/box_accum.sv
// Box accumulator: sums the four samples returning one cycle after each
// read and registers the averaged pixel as a write. Assumes the reads of
// one pixel arrive on consecutive cycles in phase order.
module box_accum
    import tile_smoother_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int AW    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  phase_e           ph,
    input  logic [AW-1:0]    ctr_addr,
    input  logic             fin,
    input  logic [PIX_W-1:0] rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [PIX_W-1:0] wr_data,
    output logic             done
);
    logic             v1, l1;
    phase_e           ph1;
    logic [AW-1:0]    a1;
    logic [PIX_W+1:0] acc, sum;

    // Running sum including the sample arriving this cycle.
    always_comb sum = acc + {2'b00, rd_data};

    // Align request tags with returning data, accumulate, emit the average.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1      <= 1'b0;
            l1      <= 1'b0;
            ph1     <= PH_CTR;
            a1      <= '0;
            acc     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            done    <= 1'b0;
        end else begin
            v1    <= take;
            l1    <= fin;
            ph1   <= ph;
            a1    <= ctr_addr;
            wr_en <= 1'b0;
            done  <= 1'b0;
            if (v1) begin
                acc <= (ph1 == PH_CTR) ? {2'b00, rd_data} : sum;
                if (ph1 == PH_DIAG) begin
                    wr_en   <= 1'b1;
                    wr_addr <= a1;
                    wr_data <= sum[PIX_W+1:2];
                    done    <= l1;
                end
            end
        end
    end

    // R6: a write follows a diagonal-phase request by exactly two cycles.
    p_write_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(take, 2) && $past(ph, 2) == PH_DIAG));

endmodule

// File: rtl/tile_smoother.sv
// Tiled 2x2 box smoother top: accepts a start when idle, walks the frame
// tile by tile issuing four reads per pixel, and writes each average.
// Assumes read data returns one cycle after rd_en and FRAME_W, FRAME_H
// are multiples of TILE (TILE >= 2).
module tile_smoother
    import tile_smoother_pkg::*;
#(
    parameter int FRAME_W = 320,
    parameter int FRAME_H = 240,
    parameter int TILE    = 10,
    parameter int PIX_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    output logic                                busy,
    output logic                                done,
    output logic                                rd_en,
    output logic [wid(FRAME_W*FRAME_H)-1:0]     rd_addr,
    input  logic [PIX_W-1:0]                    rd_data,
    output logic                                wr_en,
    output logic [wid(FRAME_W*FRAME_H)-1:0]     wr_addr,
    output logic [PIX_W-1:0]                    wr_data
);
    localparam int AW  = wid(FRAME_W * FRAME_H);
    localparam int TXW = wid(FRAME_W / TILE);
    localparam int TYW = wid(FRAME_H / TILE);
    localparam int LW  = wid(TILE);

    logic           go, run, last;
    logic [TXW-1:0] tx;
    logic [TYW-1:0] ty;
    logic [LW-1:0]  li, lj;
    phase_e         ph;
    logic [AW-1:0]  ctr_addr;

    assign go    = start && !busy;
    assign rd_en = run;

    // Busy flag: set by an accepted start, cleared after the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (go)   busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end

    tile_walker #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .TILE(TILE)) i_walker (
        .clk(clk), .rst_n(rst_n), .go(go), .run(run),
        .tx(tx), .ty(ty), .li(li), .lj(lj), .ph(ph), .last(last)
    );

    window_addr #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .TILE(TILE)) i_window (
        .tx(tx), .ty(ty), .li(li), .lj(lj), .ph(ph),
        .rd_addr(rd_addr), .ctr_addr(ctr_addr)
    );

    box_accum #(.PIX_W(PIX_W), .AW(AW)) i_accum (
        .clk(clk), .rst_n(rst_n), .take(run), .ph(ph), .ctr_addr(ctr_addr),
        .fin(last), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    // R3: every read address lies inside the frame.
    p_rd_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < FRAME_W * FRAME_H));

    // R4: the horizontal sample sits one address from the centre read before it.
    p_horiz_adj_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ph == PH_HORZ) |->
            (rd_addr == $past(rd_addr) + AW'(1) || rd_addr + AW'(1) == $past(rd_addr)));

    // R4: the vertical sample sits one frame row from the centre read two cycles before.
    p_vert_adj_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ph == PH_VERT) |->
            (rd_addr == $past(rd_addr, 2) + AW'(FRAME_W) ||
             rd_addr + AW'(FRAME_W) == $past(rd_addr, 2)));

    // R7: done lasts one cycle and occurs while busy.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: once busy, only done ends the pass; start cannot disturb it.
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/test_tile_smoother.sv
// Bench: reference model of the read sequence, write values and handshake
// timing, compared against the ports on every falling edge.
module test_tile_smoother;
    localparam int W  = 30;
    localparam int H  = 20;
    localparam int T  = 5;
    localparam int PW = 8;
    localparam int N  = W * H;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n, start;
    logic          busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [PW-1:0] rd_data, wr_data;

    logic [PW-1:0] src [N];
    int            wcount [N];
    int            exp_rd[$];
    int            exp_wa[$];
    int            exp_wd[$];
    int            vectors = 0;
    int            errors  = 0;

    always #4 clk = ~clk;

    tile_smoother #(.FRAME_W(W), .FRAME_H(H), .TILE(T), .PIX_W(PW)) i_tile_smoother (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Source memory with one-cycle read latency.
    always @(posedge clk) begin
        if (rd_en && int'(rd_addr) < N) rd_data <= src[rd_addr];
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic fill(input int pat);
        for (int a = 0; a < N; a++) begin
            case (pat)
                0:       src[a] = PW'((a * 37 + 11) % 256);
                1:       src[a] = 8'd255;
                default: src[a] = (((a % W) + (a / W)) % 2 == 1) ? 8'd255 : 8'd3;
            endcase
        end
    endtask

    // Reference sequence built from the requirements (R3, R4, R5, R6).
    task automatic build_ref();
        exp_rd.delete(); exp_wa.delete(); exp_wd.delete();
        for (int ty = 0; ty < H / T; ty++)
            for (int tx = 0; tx < W / T; tx++)
                for (int i = 0; i < T; i++)
                    for (int j = 0; j < T; j++) begin
                        int x, y, hx, vy, s;
                        x  = tx * T + j;
                        y  = ty * T + i;
                        hx = (j == T - 1) ? x - 1 : x + 1;
                        vy = (i == T - 1) ? y - 1 : y + 1;
                        exp_rd.push_back(y * W + x);
                        exp_rd.push_back(y * W + hx);
                        exp_rd.push_back(vy * W + x);
                        exp_rd.push_back(vy * W + hx);
                        s = int'(src[y*W+x]) + int'(src[y*W+hx]) + int'(src[vy*W+x]) + int'(src[vy*W+hx]);
                        exp_wa.push_back(y * W + x);
                        exp_wd.push_back(s / 4);
                    end
    endtask

    // One full pass, compared every cycle; poke drives a start mid-pass (R8).
    task automatic run_frame(input bit poke);
        int bad;
        build_ref();
        for (int a = 0; a < N; a++) wcount[a] = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= 4 * N + 3; n++) begin
            bit we;
            we = (n >= 5) && (n <= 4 * N + 1) && ((n - 5) % 4 == 0);
            chk("R2 R7 busy", int'(busy), int'(n <= 4 * N + 1));
            chk("R2 rd_en", int'(rd_en), int'(n < 4 * N));
            if (n < 4 * N) chk("R3 R4 R5 rd_addr", int'(rd_addr), exp_rd[n]);
            chk("R6 wr_en", int'(wr_en), int'(we));
            if (we) begin
                chk("R3 R6 wr_addr", int'(wr_addr), exp_wa[(n - 5) / 4]);
                chk("R6 wr_data", int'(wr_data), exp_wd[(n - 5) / 4]);
            end
            chk("R7 done", int'(done), int'(n == 4 * N + 1));
            if (wr_en && int'(wr_addr) < N) wcount[wr_addr]++;
            start = (poke && (n == 37 || n == 4 * N)) ? 1'b1 : 1'b0;  // R8 pokes
            @(negedge clk);
        end
        start = 1'b0;
        bad = 0;
        for (int a = 0; a < N; a++) if (wcount[a] != 1) bad++;
        chk("R9 pixels not written exactly once", bad, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 rd_en after reset", int'(rd_en), 0);
        chk("R1 wr_en after reset", int'(wr_en), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R2 idle without start rd_en", int'(rd_en), 0);
        end

        fill(0); run_frame(1'b0);
        fill(1); run_frame(1'b1);   // R8: starts while busy ignored

        // R1: reset in mid-frame abandons the pass.
        fill(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 busy after mid-frame reset", int'(busy), 0);
        chk("R1 rd_en after mid-frame reset", int'(rd_en), 0);
        chk("R1 wr_en after mid-frame reset", int'(wr_en), 0);
        chk("R1 done after mid-frame reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        fill(2); run_frame(1'b0);   // restarts from address 0
        summary();
    end

endmodule